// File: doc/BRIEF.md
# Dual-Bank Direct Digital Synthesis Waveform Core

The core is a numerically controlled oscillator that makes a sine, triangle or square sample stream from the master clock. It keeps two 28-bit tuning words and two 12-bit phase offsets in a small register file, which a parallel write port loads. Two select inputs choose the tuning word that feeds the 28-bit phase accumulator and the offset that is added to the accumulator's top 12 bits. The 12-bit phase sum drives a sine evaluator, a triangle folder or the square path, and the chosen result leaves the core as a registered 10-bit offset-binary sample word. The output frequency is the tuning word times the clock rate divided by 2^28, which is about 0.06 Hz per step at 16 MHz.

A separate square output carries the phase MSB, or that MSB divided by two, and it keeps running while the sample path sleeps. A small state machine controls the output stage. It has three states: HOLD (synchronous reset active), RUN (samples follow the phase) and SLEEP (sample parked at mid-scale). Its transitions are: any state to HOLD when reset is asserted; HOLD to RUN on release with sleep low; HOLD to SLEEP on release with sleep high; RUN to SLEEP when sleep rises; SLEEP to RUN when sleep falls. The state machine works from its next state, so each transition takes effect at the same edge that it is decided. Reset clears the accumulator and the divider history, but the four tuning and offset words keep their values.

Top module: `dds_wave_core`

## Requirements
- R1: When wr_en is high, a clock edge loads wr_data into the word that wr_addr names: 0 is tuning word A, 1 is tuning word B, 2 is offset A and 3 is offset B. Offsets take wr_data[11:0]. The new word is used from the next edge on. freq_sel=0 picks tuning word A and freq_sel=1 picks tuning word B. Writes happen during reset as well.
- R2: On every edge with reset low, the accumulator adds the selected tuning word, modulo 2^28.
- R3: The phase is accumulator bits [27:16] plus the offset that phase_sel picks (0 for A, 1 for B), modulo 4096.
- R4: The sample and square outputs are registered. The values after an edge come from the phase and inputs that were present before that edge.
- R5: With wave_mode 2'b00 (sine), the sample is within 5 LSB of 512 + 511*sin(2*pi*phase/4096).
- R6: With wave_mode 2'b01 (triangle), the phase's lower 11 bits are inverted when phase bit 11 is 1, and the sample is the top 10 of those 11 bits.
- R7: With wave_mode 2'b10 or 2'b11 (square), every sample bit equals the square output. With sq_half low, the square output is phase bit 11.
- R8: With sq_half high, the square output is a toggle that flips on each edge at which phase bit 11 is 1 and was 0 at the previous edge.
- R9: With dac_sleep high, the sample is 512. The accumulator and the square output keep running.
- R10: A reset edge sets the accumulator to 0, the sample to 512 and the square output to 0, and clears the MSB history and the toggle. It leaves the four words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word select for the write |
| wr_data | input | 28 | Write data |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 1 | Phase offset select |
| wave_mode | input | 2 | 00 sine, 01 triangle, 1x square |
| sq_half | input | 1 | Divide the square output by two |
| dac_sleep | input | 1 | Park the sample at mid-scale |
| sample | output | 10 | Offset-binary sample word |
| sq_out | output | 1 | Square clock output |

## Verification
The bench builds the core with its default widths: a 28-bit accumulator, a 12-bit phase and a 10-bit sample. Tuning words such as 0x0100000 then step the phase by 16 counts per clock, so a run of a few hundred cycles covers whole turns of every quadrant and many divider edges. A tuning word of 0xFFFFFFF walks the phase backwards through the modular wrap. Hand-computed first samples pin the exact values at 0, 90 and 270 degrees, and the other samples are compared each cycle against a model of the phase sum.

// File: rtl/dds_core_pkg.sv
`timescale 1ns/1ps
package dds_core_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE    = 2'b00,
        WAVE_TRI     = 2'b01,
        WAVE_SQR     = 2'b10,
        WAVE_SQR_ALT = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SLEEP = 2'b10
    } core_state_e;

    // Fixed-point weights of the odd sine series terms, scaled by 2^14.
    localparam int SIN_FRAC = 14;
    localparam int SIN_C1   = 25736;
    localparam int SIN_C3   = 10584;
    localparam int SIN_C5   = 1306;

endpackage

// File: rtl/dds_tuning_bank.sv
`timescale 1ns/1ps
module dds_tuning_bank #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             freq_sel,
    input  logic             phase_sel,
    output logic [ACC_W-1:0] freq_word,
    output logic [PH_W-1:0]  phase_word
);

    localparam int NBANK = 2;

    logic [ACC_W-1:0] freq_r  [NBANK];
    logic [PH_W-1:0]  phase_r [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [1:0] FREQ_ADDR  = {1'b0, 1'(b)};
        localparam logic [1:0] PHASE_ADDR = {1'b1, 1'(b)};

        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == FREQ_ADDR) begin
                freq_r[b] <= wr_data;
            end
            if (wr_en && wr_addr == PHASE_ADDR) begin
                phase_r[b] <= wr_data[PH_W-1:0];
            end
        end
    end

    assign freq_word  = freq_r[freq_sel];
    assign phase_word = phase_r[phase_sel];

endmodule

// File: rtl/dds_phase_accum.sv
`timescale 1ns/1ps
module dds_phase_accum #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] freq_word,
    input  logic [PH_W-1:0]  phase_word,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_sum
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + freq_word;
        end
    end

    // Offset joins only the truncated top bits, wrapping modulo 2^PH_W.
    assign phase_sum = acc_q[ACC_W-1 -: PH_W] + phase_word;

endmodule

// File: rtl/dds_wave_shaper.sv
`timescale 1ns/1ps
module dds_wave_shaper
    import dds_core_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic [PH_W-1:0]  phase,
    output logic [OUT_W-1:0] sine_s,
    output logic [OUT_W-1:0] tri_s
);

    localparam int QW   = PH_W - 2;
    localparam int MW   = 48;
    localparam int AMP  = 2 ** (OUT_W - 1) - 1;
    localparam logic [OUT_W-1:0] MID_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic [1:0]      quad;
    logic [QW-1:0]   low;
    logic [QW:0]     x;
    logic [MW-1:0]   x2, x3, x5, poly, magw;
    logic [OUT_W-2:0] mag;
    logic [PH_W-2:0] fold;

    // Quarter-wave sine by a fifth-order odd series, mirrored per quadrant.
    always_comb begin
        quad = phase[PH_W-1 -: 2];
        low  = phase[QW-1:0];
        if (quad[0]) begin
            x = {1'b1, {QW{1'b0}}} - {1'b0, low};
        end else begin
            x = {1'b0, low};
        end
        x2   = (MW'(x) * MW'(x)) >> QW;
        x3   = (x2 * MW'(x)) >> QW;
        x5   = (x3 * x2) >> QW;
        poly = ((MW'(SIN_C1) * MW'(x) + MW'(SIN_C5) * x5) - MW'(SIN_C3) * x3) >> QW;
        magw = (poly * MW'(AMP)) >> SIN_FRAC;
        if (magw > MW'(AMP)) begin
            mag = (OUT_W-1)'(AMP);
        end else begin
            mag = magw[OUT_W-2:0];
        end
        if (quad[1]) begin
            sine_s = MID_V - {1'b0, mag};
        end else begin
            sine_s = MID_V + {1'b0, mag};
        end
    end

    // Triangle: fold the descending half, keep the top sample bits.
    always_comb begin
        if (phase[PH_W-1]) begin
            fold = ~phase[PH_W-2:0];
        end else begin
            fold = phase[PH_W-2:0];
        end
        tri_s = fold[PH_W-2 -: OUT_W];
    end

endmodule

// File: rtl/dds_wave_core.sv
`timescale 1ns/1ps
module dds_wave_core
    import dds_core_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             freq_sel,
    input  logic             phase_sel,
    input  logic [1:0]       wave_mode,
    input  logic             sq_half,
    input  logic             dac_sleep,
    output logic [OUT_W-1:0] sample,
    output logic             sq_out
);

    localparam logic [OUT_W-1:0] MID_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic [ACC_W-1:0] freq_word;
    logic [PH_W-1:0]  phase_word;
    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  phase_sum;
    logic [OUT_W-1:0] sine_s, tri_s, wave_pick;
    logic             msb_now, msb_prev, div_tog, tog_nxt, sq_nxt;
    core_state_e      state_q, state_nxt;
    wave_mode_e       mode_e;

    dds_tuning_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_bank (
        .clk        (clk),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .freq_sel   (freq_sel),
        .phase_sel  (phase_sel),
        .freq_word  (freq_word),
        .phase_word (phase_word)
    );

    dds_phase_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .acc_q      (acc_q),
        .phase_sum  (phase_sum)
    );

    dds_wave_shaper #(.PH_W(PH_W), .OUT_W(OUT_W)) u_shaper (
        .phase  (phase_sum),
        .sine_s (sine_s),
        .tri_s  (tri_s)
    );

    // Square path: raw MSB or a toggle on its rising transitions.
    always_comb begin
        msb_now = phase_sum[PH_W-1];
        tog_nxt = div_tog ^ (msb_now & ~msb_prev);
        sq_nxt  = sq_half ? tog_nxt : msb_now;
    end

    always_comb begin
        mode_e = wave_mode_e'(wave_mode);
        unique case (mode_e)
            WAVE_SINE:             wave_pick = sine_s;
            WAVE_TRI:              wave_pick = tri_s;
            WAVE_SQR, WAVE_SQR_ALT: wave_pick = {OUT_W{sq_nxt}};
            default:               wave_pick = MID_V;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (rst)            state_nxt = ST_HOLD;
                else if (dac_sleep) state_nxt = ST_SLEEP;
                else                state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (rst)            state_nxt = ST_HOLD;
                else if (dac_sleep) state_nxt = ST_SLEEP;
                else                state_nxt = ST_RUN;
            end
            ST_SLEEP: begin
                if (rst)             state_nxt = ST_HOLD;
                else if (!dac_sleep) state_nxt = ST_RUN;
                else                 state_nxt = ST_SLEEP;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_nxt;
    end

    // Output process, driven by the state being entered.
    always_ff @(posedge clk) begin
        unique case (state_nxt)
            ST_RUN: begin
                sample   <= wave_pick;
                sq_out   <= sq_nxt;
                msb_prev <= msb_now;
                div_tog  <= tog_nxt;
            end
            ST_SLEEP: begin
                sample   <= MID_V;
                sq_out   <= sq_nxt;
                msb_prev <= msb_now;
                div_tog  <= tog_nxt;
            end
            default: begin
                sample   <= MID_V;
                sq_out   <= 1'b0;
                msb_prev <= 1'b0;
                div_tog  <= 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dds_core_checker.sv
`timescale 1ns/1ps
module dds_core_checker #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int OUT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             dac_sleep,
    input logic [1:0]       wave_mode,
    input logic             sq_half,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] freq_word,
    input logic             phase_msb,
    input logic [OUT_W-1:0] sample,
    input logic             sq_out
);

    localparam logic [OUT_W-1:0] MID_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(rst) |-> acc_q == $past(acc_q) + $past(freq_word));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample == MID_V && !sq_out && acc_q == '0));

    assert_sleep_mid_R9: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(rst) && $past(dac_sleep) |-> sample == MID_V);

    assert_square_rail_R7: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(rst) && !$past(dac_sleep) && $past(wave_mode[1])
        |-> ((sample == '1 || sample == '0) && sample[0] == sq_out));

    assert_square_msb_R7: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(rst) && !$past(sq_half) |-> sq_out == $past(phase_msb));

    assert_divide_hold_R8: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(rst) && $past(sq_half) && $past(sq_half, 2) && !$past(phase_msb)
        |-> $stable(sq_out));

endmodule

bind dds_wave_core dds_core_checker #(
    .ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .dac_sleep (dac_sleep),
    .wave_mode (wave_mode),
    .sq_half   (sq_half),
    .acc_q     (acc_q),
    .freq_word (freq_word),
    .phase_msb (phase_sum[PH_W-1]),
    .sample    (sample),
    .sq_out    (sq_out)
);

// File: tb/test_dds_wave_core.sv
`timescale 1ns/1ps
module test_dds_wave_core;

    localparam int ACC_W = 28;
    localparam int PH_W  = 12;
    localparam int OUT_W = 10;
    localparam int MIDV  = 512;
    localparam int NVEC  = 8;
    localparam int RUNLEN = 300;

    // {mode[53:52], half[51], bank[50], tuning[49:22], offset[21:10], first sample[9:0]}
    localparam logic [53:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 28'h0100000, 12'h000, 10'd512},
        {2'd0, 1'b0, 1'b1, 28'h0123456, 12'h400, 10'd1023},
        {2'd1, 1'b0, 1'b0, 28'h0200000, 12'h400, 10'd512},
        {2'd1, 1'b0, 1'b1, 28'h0F0F0F0, 12'hC00, 10'd511},
        {2'd2, 1'b0, 1'b0, 28'h0400000, 12'h800, 10'd1023},
        {2'd2, 1'b1, 1'b1, 28'h0400000, 12'h000, 10'd0},
        {2'd3, 1'b1, 1'b0, 28'h07FFFFF, 12'h800, 10'd1023},
        {2'd1, 1'b0, 1'b1, 28'hFFFFFFF, 12'h000, 10'd0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [1:0]       wr_addr;
    logic [ACC_W-1:0] wr_data;
    logic             freq_sel, phase_sel;
    logic [1:0]       wave_mode;
    logic             sq_half, dac_sleep;
    logic [OUT_W-1:0] sample;
    logic             sq_out;

    dds_wave_core #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) i_dds_wave_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .freq_sel(freq_sel), .phase_sel(phase_sel), .wave_mode(wave_mode),
        .sq_half(sq_half), .dac_sleep(dac_sleep), .sample(sample), .sq_out(sq_out)
    );

    always #10 clk = ~clk;

    // Reference model state, built from the requirements.
    logic [27:0] m_freq [2];
    logic [11:0] m_ph   [2];
    logic [27:0] m_acc;
    bit  m_prev, m_tog, m_sq, m_sine;
    int  m_sample;
    real m_ideal;
    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit chk);
        logic [11:0] p;
        bit msb, togn, sqn;
        p    = m_acc[27:16] + m_ph[phase_sel];
        msb  = p[11];
        togn = m_tog ^ (msb & ~m_prev);
        sqn  = sq_half ? togn : msb;
        @(posedge clk);
        m_sine = 0;
        if (rst) begin
            m_acc = '0; m_prev = 0; m_tog = 0; m_sq = 0; m_sample = MIDV;
        end else begin
            m_acc  = m_acc + m_freq[freq_sel];
            m_prev = msb; m_tog = togn; m_sq = sqn;
            if (dac_sleep) m_sample = MIDV;
            else if (wave_mode == 2'b00) begin
                m_sine  = 1;
                m_ideal = 512.0 + 511.0 * $sin(6.283185307179586 * real'(p) / 4096.0);
            end else if (wave_mode == 2'b01) begin
                m_sample = p[11] ? int'((~p[10:0]) >> 1) & 1023 : int'(p[10:1]);
            end else m_sample = sqn ? 1023 : 0;
        end
        if (wr_en) begin
            if (wr_addr[1]) m_ph[wr_addr[0]] = wr_data[11:0];
            else            m_freq[wr_addr[0]] = wr_data;
        end
        @(negedge clk);
        if (chk) begin
            if (m_sine) begin
                n_chk++;
                if ((real'(sample) - m_ideal > 5.0) || (m_ideal - real'(sample) > 5.0)) begin
                    n_fail++;
                    $display("FAIL %s: sample actual=%0d expected=%0d (+/-5)", tag, sample, $rtoi(m_ideal));
                end
            end else check_eq({tag, " sample"}, int'(sample), m_sample);
            check_eq({tag, " sq_out"}, int'(sq_out), int'(m_sq));
        end
    endtask

    task automatic write_word(input logic [1:0] a, input logic [27:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step("R1 write", 1);
        wr_en = 0;
    endtask

    function automatic string tag_of(input logic [1:0] mode, input logic half);
        if (mode == 2'b00) return "R5 sine R2 R3 R4";
        if (mode == 2'b01) return "R6 triangle R2 R3 R4";
        if (half)          return "R8 divided square";
        return "R7 square";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int toggles;
        bit last_sq;
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; freq_sel = 0; phase_sel = 0;
        wave_mode = 0; sq_half = 0; dac_sleep = 0;
        m_acc = 0; m_prev = 0; m_tog = 0; m_sq = 0; m_sample = MIDV; m_sine = 0;
        @(negedge clk);
        // R10: reset state, and R1 writes accepted while in reset.
        write_word(2'd0, 28'h0000000);
        write_word(2'd1, 28'h0000000);
        write_word(2'd2, 28'h000);
        write_word(2'd3, 28'h000);
        check_eq("R10 reset sample", int'(sample), MIDV);
        check_eq("R10 reset sq_out", int'(sq_out), 0);

        // Vector table: each entry loads one bank, scribbles the other, runs.
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] md; logic hf, bk; logic [27:0] fw; logic [11:0] ow; int first;
            md = VECS[i][53:52]; hf = VECS[i][51]; bk = VECS[i][50];
            fw = VECS[i][49:22]; ow = VECS[i][21:10]; first = int'(VECS[i][9:0]);
            rst = 1;
            write_word({1'b0, bk}, fw);
            write_word({1'b1, bk}, {16'd0, ow});
            write_word({1'b0, ~bk}, 28'h5A5A5A5);
            write_word({1'b1, ~bk}, 28'h0000777);
            freq_sel = bk; phase_sel = bk; wave_mode = md; sq_half = hf;
            rst = 0;
            step(tag_of(md, hf), 1);
            check_eq("R4 R1 first sample after reset", int'(sample), first);
            for (int c = 0; c < RUNLEN; c++) step(tag_of(md, hf), 1);
        end

        // R9: sleep parks the sample while the divided square keeps running.
        rst = 1;
        write_word(2'd0, 28'h0800000);
        write_word(2'd2, 28'h100);
        freq_sel = 0; phase_sel = 0; wave_mode = 2'b10; sq_half = 1;
        rst = 0;
        for (int c = 0; c < 20; c++) step("R8 divided square", 1);
        dac_sleep = 1;
        toggles = 0; last_sq = sq_out;
        for (int c = 0; c < 100; c++) begin
            step("R9 sleep", 1);
            if (sq_out != last_sq) toggles++;
            last_sq = sq_out;
        end
        n_chk++;
        if (toggles == 0) begin
            n_fail++;
            $display("FAIL R9 square during sleep: actual=%0d toggles expected=>0", toggles);
        end
        dac_sleep = 0;
        wave_mode = 2'b01;
        for (int c = 0; c < 50; c++) step("R9 wake R6", 1);

        // R1 R3: switch tuning and offset selects during a run.
        write_word(2'd1, 28'h0345678);
        write_word(2'd3, 28'h9C3);
        for (int c = 0; c < 200; c++) begin
            if (c % 7 == 0) freq_sel = ~freq_sel;
            if (c % 11 == 0) phase_sel = ~phase_sel;
            step("R3 select switching R1", 1);
        end

        // R10: reset mid-run keeps the words; first sample is the offset fold.
        freq_sel = 0; phase_sel = 1; wave_mode = 2'b01; sq_half = 0;
        write_word(2'd3, 28'h400);
        rst = 1;
        step("R10 reset", 1);
        step("R10 reset", 1);
        check_eq("R10 accumulator cleared sample", int'(sample), MIDV);
        rst = 0;
        step("R10 release", 1);
        check_eq("R10 words kept, offset B fold", int'(sample), 512);
        for (int c = 0; c < 40; c++) step("R6 R2 after reset", 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule